// File: doc/BRIEF.md
# Flash Array Program/Erase Controller

This block models a small on-chip flash array together with the logic that programs and erases it. A CPU-side bus reaches either the byte-wide array or a three-bit control register. Array cells power up erased, reading as ones. A normal bus write never changes the array. Software first sets the arm bit. The next array write is captured into a programming latch as an address and data pair. Setting the run-enable bit then starts a timed operation. A program operation ANDs the latched data into the stored cells, so it can only clear bits. An erase operation returns every cell of the array to ones.

A control FSM with the states P_IDLE, P_ARMED, P_LOADED, P_RUN and P_DONE tracks this sequence. The transitions are as follows:
- P_IDLE goes to P_ARMED when a control write sets arm.
- P_ARMED goes to P_LOADED on the capturing array write.
- P_LOADED goes to P_RUN when a control write raises enable while keeping arm set.
- P_RUN goes to P_DONE when the cycle count runs out. It goes back to P_LOADED if enable is cleared first, which aborts the operation.
- P_DONE goes to P_LOADED when enable is cleared.
- Every state except P_IDLE returns to P_IDLE when a control write clears arm.

A bus FSM with the states B_FIRST and B_SECOND adds one extra cycle for a misaligned word access. B_FIRST goes to B_SECOND on a misaligned word request. B_SECOND always returns to B_FIRST. Reads are redirected to the latch, or suppressed, depending on the control bits.

Top module: `flash_pe_ctrl`

## Requirements
- R1: Cells read 1 after power-up. A program operation ANDs the latched data into the stored bytes, so no bit ever changes from 0 to 1 through programming. An erase operation sets every byte of the array to 8'hFF, whichever address was latched.
- R2: While arm (control bit 0) is clear, array writes leave the array unchanged.
- R3: A request is held until bus_ack. Byte accesses, aligned word accesses and all control accesses are acknowledged in their first cycle. A word access to an odd array address is acknowledged in its second cycle. A word at address A returns {byte[A+1], byte[A]}, and the address wraps modulo the array size.
- R4: Each operation programs exactly one unit. A byte write programs the addressed byte with wdata[7:0]. An aligned word write programs both bytes. A misaligned word write captured into the latch programs only the odd byte, with wdata[7:0].
- R5: The first array write after arm is set is captured into the latch. Further array writes are ignored until arm is cleared.
- R6: The read result depends on the control bits when enable is 0. With arm=0, a read returns the addressed location. With arm=1, erase=0 and a captured latch, a read returns the latched data (byte data zero-extended). With arm=1 and erase=1, a read returns the addressed location.
- R7: While enable (control bit 2) is 1, array reads return 16'hFFFF, and rd_ignored pulses together with rd_valid.
- R8: An operation starts only on a control write that raises enable while arm stays 1 and the latch holds data. busy is then high for exactly OP_CYCLES cycles and the array is updated as busy falls. A write that sets enable with arm=0 starts nothing.
- R9: Clearing enable during an operation aborts it and leaves the array unchanged. Clearing arm empties the latch.
- R10: A control read returns {busy, enable, erase, arm} in bits 3..0 with zeros above. Control writes take effect at any time, including during an operation.
- R11: Reset clears the control register and the latch and keeps the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_ctrl | input | 1 | 1 = control register, 0 = array |
| bus_addr | input | AW | Array byte address |
| bus_wdata | input | 16 | Write data (control uses bits 2..0: enable, erase, arm) |
| bus_ack | output | 1 | Access completes at this clock edge |
| rd_data | output | 16 | Read result, valid while rd_valid |
| rd_valid | output | 1 | One-cycle pulse after an acknowledged read |
| rd_ignored | output | 1 | Pulse marking a suppressed array read |
| busy | output | 1 | Program or erase in progress |

## Verification
The assertions assume that a request keeps its attributes stable until bus_ack. They also assume that only one access is in flight at a time. The bench meets this by issuing every access from one task: it raises bus_req at a falling edge, holds every field until it sees bus_ack, and drops the request just after the accepting edge. The bench never drives a misaligned word to the control register. The bench changes reset only at falling edges, away from any access.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [2:0] {
        P_IDLE,
        P_ARMED,
        P_LOADED,
        P_RUN,
        P_DONE
    } pe_state_t;

    typedef enum logic {
        B_FIRST,
        B_SECOND
    } bus_state_t;

    typedef struct packed {
        logic en;
        logic erase;
        logic arm;
    } ctrl_t;

    localparam logic [15:0] READ_SUPPRESSED = 16'hFFFF;
    localparam logic [7:0]  ERASED_BYTE     = 8'hFF;

endpackage

// File: rtl/flash_pe_bus.sv
module flash_pe_bus
    import flash_pe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic word,
    input  logic ctrl,
    input  logic addr_lsb,
    output logic ack
);

    bus_state_t st, st_nx;
    logic       split;

    assign split = req & word & addr_lsb & ~ctrl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= B_FIRST;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            B_FIRST:  if (split) st_nx = B_SECOND;
            B_SECOND: st_nx = B_FIRST;
            default:  st_nx = B_FIRST;
        endcase
    end

    always_comb begin
        ack = 1'b0;
        unique case (st)
            B_FIRST:  ack = req & ~split;
            B_SECOND: ack = 1'b1;
            default:  ack = 1'b0;
        endcase
    end

    // R3: a misaligned word is never accepted in its first cycle
    a_r3_split_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_FIRST && split) |-> !ack);

    // R3: the misaligned word completes exactly one cycle later
    a_r3_split_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == B_FIRST && split) |=> ack);

endmodule

// File: rtl/flash_pe_array.sv
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    input  logic          prog,
    input  logic          erase,
    input  logic [AW-1:0] lat_addr,
    input  logic [15:0]   lat_data,
    input  logic          lat_word,
    output logic [7:0]    rd_lo,
    output logic [7:0]    rd_hi
);

    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_addr_nx;
    logic [AW-1:0] lat_addr_hi;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = ERASED_BYTE;
    end

    assign rd_addr_nx  = rd_addr + AW'(1);
    assign lat_addr_hi = lat_addr | AW'(1);

    always_ff @(posedge clk) begin
        if (erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (prog) begin
            mem[lat_addr] <= mem[lat_addr] & lat_data[7:0];
            if (lat_word) mem[lat_addr_hi] <= mem[lat_addr_hi] & lat_data[15:8];
        end
    end

    assign rd_lo = mem[rd_addr];
    assign rd_hi = mem[rd_addr_nx];

    // R1: without an erase, no stored bit may rise
    a_r1_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !erase |=> ((mem[0] & ~$past(mem[0])) == 8'h00));

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int AW        = 6,
    parameter int OP_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [2:0]    ctrl_wdata,
    input  logic          arr_wr,
    input  logic [AW-1:0] wr_addr,
    input  logic [15:0]   wr_data,
    input  logic          wr_word,
    output ctrl_t         ctrl_q,
    output logic          busy,
    output logic          lat_full,
    output logic [AW-1:0] lat_addr,
    output logic [15:0]   lat_data,
    output logic          lat_word,
    output logic          do_prog,
    output logic          do_erase
);

    localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

    pe_state_t  st, st_nx;
    ctrl_t      wr_ctrl;
    logic [CNT_W-1:0] cnt;
    logic       start, abort, expire, cap, cap_word, op_erase;

    assign wr_ctrl  = ctrl_t'(ctrl_wdata);
    assign start    = ctrl_wr && wr_ctrl.en && wr_ctrl.arm && !ctrl_q.en && st == P_LOADED;
    assign abort    = ctrl_wr && (!wr_ctrl.arm || !wr_ctrl.en);
    assign expire   = (st == P_RUN) && (cnt == '0) && !abort;
    assign cap      = arr_wr && (st == P_ARMED);
    assign cap_word = wr_word & ~wr_addr[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= P_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            P_IDLE:   if (ctrl_wr && wr_ctrl.arm) st_nx = P_ARMED;
            P_ARMED:  if (ctrl_wr && !wr_ctrl.arm) st_nx = P_IDLE;
                      else if (arr_wr) st_nx = P_LOADED;
            P_LOADED: if (ctrl_wr && !wr_ctrl.arm) st_nx = P_IDLE;
                      else if (start) st_nx = P_RUN;
            P_RUN:    if (ctrl_wr && !wr_ctrl.arm) st_nx = P_IDLE;
                      else if (ctrl_wr && !wr_ctrl.en) st_nx = P_LOADED;
                      else if (cnt == '0) st_nx = P_DONE;
            P_DONE:   if (ctrl_wr && !wr_ctrl.arm) st_nx = P_IDLE;
                      else if (ctrl_wr && !wr_ctrl.en) st_nx = P_LOADED;
            default:  st_nx = P_IDLE;
        endcase
    end

    always_comb begin
        busy     = (st == P_RUN);
        lat_full = (st == P_LOADED) || (st == P_RUN) || (st == P_DONE);
        do_prog  = expire && !op_erase;
        do_erase = expire && op_erase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cnt      <= '0;
            op_erase <= 1'b0;
            lat_addr <= '0;
            lat_data <= '0;
            lat_word <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= wr_ctrl;
            if (start) begin
                cnt      <= CNT_W'(OP_CYCLES - 1);
                op_erase <= wr_ctrl.erase;
            end else if (st == P_RUN && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (cap) begin
                lat_addr <= wr_addr;
                lat_data <= cap_word ? wr_data : {8'h00, wr_data[7:0]};
                lat_word <= cap_word;
            end
        end
    end

    // R5: any state past P_IDLE implies arm is set
    a_r5_armed_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st != P_IDLE) |-> ctrl_q.arm);

    // R5: a captured latch holds its contents
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lat_full |=> (!lat_full || ($stable(lat_addr) && $stable(lat_data))));

    // R8: an operation only runs while enable is set
    a_r8_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ctrl_q.en);

    // R8: an operation starts only from a loaded latch
    a_r8_start_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(lat_full));

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int AW        = 6,
    parameter int OP_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_write,
    input  logic          bus_word,
    input  logic          bus_ctrl,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic          bus_ack,
    output logic [15:0]   rd_data,
    output logic          rd_valid,
    output logic          rd_ignored,
    output logic          busy
);

    ctrl_t         ctrl_q;
    logic          acc, rd_acc, lat_full, lat_word, do_prog, do_erase, rd_ign;
    logic [AW-1:0] lat_addr;
    logic [15:0]   lat_data, rd_val;
    logic [7:0]    rd_lo, rd_hi;

    assign acc    = bus_req & bus_ack;
    assign rd_acc = acc & ~bus_write;

    flash_pe_bus u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .word     (bus_word),
        .ctrl     (bus_ctrl),
        .addr_lsb (bus_addr[0]),
        .ack      (bus_ack)
    );

    flash_pe_seq #(.AW(AW), .OP_CYCLES(OP_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (acc & bus_write & bus_ctrl),
        .ctrl_wdata (bus_wdata[2:0]),
        .arr_wr     (acc & bus_write & ~bus_ctrl),
        .wr_addr    (bus_addr),
        .wr_data    (bus_wdata),
        .wr_word    (bus_word),
        .ctrl_q     (ctrl_q),
        .busy       (busy),
        .lat_full   (lat_full),
        .lat_addr   (lat_addr),
        .lat_data   (lat_data),
        .lat_word   (lat_word),
        .do_prog    (do_prog),
        .do_erase   (do_erase)
    );

    flash_pe_array #(.AW(AW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (bus_addr),
        .prog     (do_prog),
        .erase    (do_erase),
        .lat_addr (lat_addr),
        .lat_data (lat_data),
        .lat_word (lat_word),
        .rd_lo    (rd_lo),
        .rd_hi    (rd_hi)
    );

    always_comb begin
        rd_ign = 1'b0;
        if (bus_ctrl) begin
            rd_val = {12'h000, busy, ctrl_q.en, ctrl_q.erase, ctrl_q.arm};
        end else if (ctrl_q.en) begin
            rd_val = READ_SUPPRESSED;
            rd_ign = 1'b1;
        end else if (ctrl_q.arm && !ctrl_q.erase && lat_full) begin
            rd_val = lat_data;
        end else begin
            rd_val = bus_word ? {rd_hi, rd_lo} : {8'h00, rd_lo};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_ignored <= 1'b0;
            rd_data    <= '0;
        end else begin
            rd_valid   <= rd_acc;
            rd_ignored <= rd_acc & rd_ign;
            if (rd_acc) rd_data <= rd_val;
        end
    end

    // R7: a suppressed read is always a completed read
    a_r7_ignored_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ignored |-> rd_valid);

    // R7: a suppressed read returns all ones
    a_r7_ignored_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ignored |-> (rd_data == 16'hFFFF));

endmodule

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int OPC        = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_write = 1'b0, bus_word = 1'b0, bus_ctrl = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [15:0]   bus_wdata = '0;
    logic          bus_ack, rd_valid, rd_ignored, busy;
    logic [15:0]   rd_data;

    int n_checks = 0, n_fail = 0, busy_seen = 0;
    bit done = 0;

    logic [15:0] q_val[$];
    logic        q_ign[$];
    string       q_tag[$];

    flash_pe_ctrl #(.AW(AW), .OP_CYCLES(OPC)) i_flash_pe_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_write(bus_write),
        .bus_word(bus_word), .bus_ctrl(bus_ctrl), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ignored(rd_ignored), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // monitor: pops expected reads from the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (q_val.size() == 0) begin
                check(0, "unexpected read", {15'd0, rd_ignored, rd_data}, 32'd0);
            end else begin
                automatic logic [15:0] ev = q_val.pop_front();
                automatic logic        ei = q_ign.pop_front();
                automatic string       et = q_tag.pop_front();
                check(rd_data == ev && rd_ignored == ei, et,
                      {15'd0, rd_ignored, rd_data}, {15'd0, ei, ev});
            end
        end
        if (busy) busy_seen++;
    end

    task automatic access(input logic c, input logic w, input logic wd,
                          input logic [AW-1:0] a, input logic [15:0] d, output int n);
        @(negedge clk);
        bus_req = 1; bus_ctrl = c; bus_write = w; bus_word = wd; bus_addr = a; bus_wdata = d;
        n = 1;
        #1;
        while (!bus_ack) begin
            @(negedge clk); #1; n++;
        end
        @(posedge clk); #1;
        bus_req = 0; bus_write = 0;
    endtask

    task automatic rd(input logic c, input logic wd, input logic [AW-1:0] a,
                      input logic [15:0] ev, input logic ei, input string tag);
        int n;
        q_val.push_back(ev); q_ign.push_back(ei); q_tag.push_back(tag);
        access(c, 0, wd, a, 16'h0, n);
    endtask

    task automatic wr(input logic c, input logic wd, input logic [AW-1:0] a, input logic [15:0] d);
        int n;
        access(c, 1, wd, a, d, n);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic run_prog(input logic wd, input logic [AW-1:0] a, input logic [15:0] d);
        wr(1, 0, 0, 16'h1);
        wr(0, wd, a, d);
        wr(1, 0, 0, 16'h5);
        @(negedge clk);
        wait_idle();
        wr(1, 0, 0, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        check(busy == 0, "R11 busy after reset", {31'd0, busy}, 32'd0);
        rd(1, 0, 0, 16'h0000, 0, "R11 control reset");
        // R1 erased
        rd(0, 1, 0, 16'hFFFF, 0, "R1 erased word");
        rd(0, 0, 5, 16'h00FF, 0, "R1 erased byte");
        // R2 write while disarmed
        wr(0, 1, 4, 16'h1234);
        rd(0, 1, 4, 16'hFFFF, 0, "R2 disarmed write ignored");
        // R3 acceptance timing
        q_val.push_back(16'h00FF); q_ign.push_back(0); q_tag.push_back("R3 byte data");
        access(0, 0, 0, 3, 0, n);
        check(n == 1, "R3 byte one cycle", n, 1);
        q_val.push_back(16'hFFFF); q_ign.push_back(0); q_tag.push_back("R3 word data");
        access(0, 0, 1, 4, 0, n);
        check(n == 1, "R3 aligned word one cycle", n, 1);
        q_val.push_back(16'hFFFF); q_ign.push_back(0); q_tag.push_back("R3 split data");
        access(0, 0, 1, 7, 0, n);
        check(n == 2, "R3 misaligned word two cycles", n, 2);

        // R5/R6/R7/R8/R10 first program
        wr(1, 0, 0, 16'h1);
        rd(1, 0, 0, 16'h0001, 0, "R10 arm readback");
        wr(0, 1, 4, 16'h12F4);
        wr(0, 1, 8, 16'h0000);
        rd(0, 1, 0, 16'h12F4, 0, "R6 latched data read");
        busy_seen = 0;
        wr(1, 0, 0, 16'h5);
        rd(1, 0, 0, 16'h000D, 0, "R10 busy readback");
        rd(0, 1, 4, 16'hFFFF, 1, "R7 suppressed read");
        wait_idle();
        check(busy_seen == OPC, "R8 busy length", busy_seen, OPC);
        wr(1, 0, 0, 16'h1);
        wr(1, 0, 0, 16'h0);
        rd(0, 1, 4, 16'h12F4, 0, "R4 aligned word programmed");
        rd(0, 1, 8, 16'hFFFF, 0, "R5 second write ignored");

        // R1 AND only
        run_prog(1, 4, 16'hFF0F);
        rd(0, 1, 4, 16'h1204, 0, "R1 program cannot raise bits");
        // R4 byte program
        run_prog(0, 9, 16'hAA3C);
        rd(0, 1, 8, 16'h3CFF, 0, "R4 byte program");
        // R4 misaligned word captured as odd byte
        wr(1, 0, 0, 16'h1);
        access(0, 1, 1, 11, 16'h5A0F, n);
        check(n == 2, "R3 misaligned write two cycles", n, 2);
        wr(1, 0, 0, 16'h5);
        @(negedge clk);
        wait_idle();
        wr(1, 0, 0, 16'h0);
        rd(0, 1, 10, 16'h0FFF, 0, "R4 misaligned programs odd byte");
        rd(0, 0, 12, 16'h00FF, 0, "R4 neighbour untouched");

        // R8 enable with arm cleared
        wr(1, 0, 0, 16'h1);
        wr(0, 0, 0, 16'h0000);
        busy_seen = 0;
        wr(1, 0, 0, 16'h4);
        repeat (3) @(negedge clk);
        check(busy_seen == 0, "R8 no start without arm", busy_seen, 0);
        wr(1, 0, 0, 16'h0);
        rd(0, 0, 0, 16'h00FF, 0, "R8 array unchanged");

        // R9 abort
        wr(1, 0, 0, 16'h1);
        wr(0, 0, 1, 16'h0000);
        wr(1, 0, 0, 16'h5);
        repeat (3) @(negedge clk);
        check(busy == 1, "R9 running before abort", {31'd0, busy}, 32'd1);
        wr(1, 0, 0, 16'h1);
        @(negedge clk);
        check(busy == 0, "R10 abort write takes effect", {31'd0, busy}, 32'd0);
        wr(1, 0, 0, 16'h0);
        rd(0, 0, 1, 16'h00FF, 0, "R9 abort leaves array");
        wr(1, 0, 0, 16'h1);
        rd(0, 1, 0, 16'hFFFF, 0, "R9 arm clear empties latch");

        // R6 erase decode and R1 erase
        wr(1, 0, 0, 16'h3);
        wr(0, 1, 20, 16'h0000);
        rd(0, 1, 4, 16'h1204, 0, "R6 erase mode normal read");
        wr(1, 0, 0, 16'h7);
        @(negedge clk);
        wait_idle();
        wr(1, 0, 0, 16'h0);
        rd(0, 1, 4, 16'hFFFF, 0, "R1 erase word 4");
        rd(0, 1, 10, 16'hFFFF, 0, "R1 erase word 10");
        rd(0, 1, 8, 16'hFFFF, 0, "R1 erase word 8");

        // R11 reset keeps array
        run_prog(0, 0, 16'h0077);
        wr(1, 0, 0, 16'h1);
        wr(0, 0, 5, 16'h0000);
        repeat (3) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        rd(1, 0, 0, 16'h0000, 0, "R11 control cleared");
        rd(0, 1, 4, 16'hFFFF, 0, "R11 latch cleared");
        q_val.push_back(16'h77FF); q_ign.push_back(0); q_tag.push_back("R3 R11 wrap read keeps array");
        access(0, 0, 1, 63, 0, n);

        repeat (4) @(negedge clk);
        check(q_val.size() == 0, "scoreboard drained", q_val.size(), 0);
        finish_run();
    end

endmodule